// File: doc/BRIEF.md
# Interrupt Acknowledge and Vector Unit

This block gathers interrupt requests from a set of on-chip peripheral sources and decides which one the processor should service. Each source has a configured urgency level and a configured recognition style: edge sources latch a request when their input rises, level sources are pending for as long as their input is held high. A fixed-length priority pass selects the most urgent eligible source. When one is found, the unit raises its request line to the processor and, in the same cycle, latches the low sixteen bits of that source's entry address in the handler table.

Software talks to the unit over a small halfword register bus with two registers: a read-only vector register and a read/write mask register. Reading the vector register is the acknowledge. That single read writes the winner's level into the mask, clears the winner's latched request (edge sources only), drops the processor request and starts a fresh priority pass. Software is expected to save the mask before the acknowledging read and restore it once the handler is done.

Top module: `irq_vector_ack`

## Requirements
- R1: After reset the processor request `irq_o` is low, no request is pending and the mask register reads back 7.
- R2: An edge source becomes pending on a rising edge of its input. Further rising edges while it is pending merge into that one request, so it is accepted only once.
- R3: A level source is pending exactly while its input is high. An acknowledge does not clear it, so it is accepted again once the mask allows it.
- R4: A pending source is eligible only if its 3-bit level is numerically lower than the mask. Level 7 never wins.
- R5: Among eligible sources the lowest level wins. On equal levels the lowest source index wins.
- R6: A priority pass takes RES_CYC cycles. When it finds a winner, `irq_o` rises and the vector register updates in the same cycle, to 0x0094 + 4 × source index.
- R7: A read of the vector register (bus_addr 0) while `irq_o` is high is the acknowledge. `irq_o` is low in the following cycle and a new priority pass starts.
- R8: An acknowledge loads the winner's level into the mask register.
- R9: An acknowledge clears the pending request of the winning edge source.
- R10: A read of the vector register while `irq_o` is low has no side effect. The mask and the pending requests are left unchanged.
- R11: The mask register (bus_addr 1) is written from bus_wdata[2:0] and reads back zero-extended to 16 bits. Read data appears on bus_rdata in the cycle after bus_rd.
- R12: The vector register is read-only. A write to bus_addr 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | NSRC | Request inputs from the peripheral sources |
| cfg_prio | input | 3*NSRC | Level of each source; source i occupies bits [3i+2:3i]; 7 disables the source |
| cfg_level | input | NSRC | 1 = source is level-recognized, 0 = edge-latched |
| bus_addr | input | 1 | Register select: 0 vector register, 1 mask register |
| bus_rd | input | 1 | Halfword read strobe |
| bus_wr | input | 1 | Halfword write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench runs a behavioural model next to the design and compares the request line and every read result on each clock. Two edges on one source while it is masked show merging, because exactly one acceptance follows. A simultaneous pair of equal-level sources tests the index tie-break, and a spread of levels tests the level ordering. Holding a level source through two acknowledges separates level from edge clearing. Reads of the vector register with no request outstanding, together with writes to it, must leave the mask and the vector untouched. A level-7 source that is pending must never be accepted.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_OFF = 3'd7;
  localparam logic [15:0] VEC_BASE = 16'h0094;
  localparam logic [15:0] VEC_LAST = 16'h010F;
  localparam int MAX_SRC = 31;
  typedef enum logic {REG_VEC = 1'b0, REG_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/irqv_src_latch.sv
module irqv_src_latch (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic is_level,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic rise;

  assign rise = src & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= src;
      if (is_level) pend <= src;
      else          pend <= rise | (pend & ~clr);
    end
  end

  // R3: a level source mirrors its input one cycle later
  a_r3_level_follow: assert property (@(posedge clk) disable iff (rst)
    (is_level && !$past(rst)) |-> (pend == $past(src)));

  // R9: a cleared edge request with no new edge is gone next cycle
  a_r9_edge_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !is_level && !rise) |=> !pend);
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input  logic [NSRC-1:0]       pend,
  input  logic [NSRC*LVL_W-1:0] prio,
  input  logic [LVL_W-1:0]      mask,
  output logic                  found,
  output logic [IDX_W-1:0]      idx,
  output logic [LVL_W-1:0]      lvl
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    lvl   = LVL_OFF;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (prio[i*LVL_W +: LVL_W] < mask) &&
          (prio[i*LVL_W +: LVL_W] < lvl)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        lvl   = prio[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irqv_sequencer.sv
module irqv_sequencer
  import irqv_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int RES_CYC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  input  logic             found,
  input  logic [IDX_W-1:0] found_idx,
  input  logic [LVL_W-1:0] found_lvl,
  output logic             irq_o,
  output logic [15:0]      vec_o,
  output logic [IDX_W-1:0] win_idx,
  output logic [LVL_W-1:0] win_lvl
);
  localparam int CNT_W = (RES_CYC > 1) ? $clog2(RES_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(RES_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             decide;

  assign decide = !irq_o && (cnt_q == CNT_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      irq_o   <= 1'b0;
      win_idx <= '0;
      win_lvl <= LVL_OFF;
    end else if (ack) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else if (!irq_o) begin
      if (decide) begin
        cnt_q <= '0;
        if (found) begin
          irq_o   <= 1'b1;
          win_idx <= found_idx;
          win_lvl <= found_lvl;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // vector holds no reset value; it is defined from the first acceptance on
  always_ff @(posedge clk) begin
    if (!rst && decide && found && !ack)
      vec_o <= VEC_BASE + {found_idx, 2'b00};
  end

  // R6: an outstanding request always points into the handler table
  a_r6_vec_range: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (vec_o[1:0] == 2'b00 && vec_o >= VEC_BASE && vec_o <= VEC_LAST));

  // R7: the request is held until acknowledged
  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack) |=> irq_o);
endmodule

// File: rtl/irq_vector_ack.sv
module irq_vector_ack
  import irqv_pkg::*;
#(
  parameter int NSRC    = 8,
  parameter int RES_CYC = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       src_req,
  input  logic [NSRC*LVL_W-1:0] cfg_prio,
  input  logic [NSRC-1:0]       cfg_level,
  input  logic                  bus_addr,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [15:0]           bus_wdata,
  output logic [15:0]           bus_rdata,
  output logic                  irq_o
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  clr;
  logic [LVL_W-1:0] mask_q;
  logic             found;
  logic [IDX_W-1:0] found_idx;
  logic [LVL_W-1:0] found_lvl;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic [15:0]      vec;
  logic             ack;
  logic             vec_rd;

  assign vec_rd = bus_rd && (bus_addr == REG_VEC);
  assign ack    = vec_rd && irq_o;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign clr[g] = ack && (win_idx == IDX_W'(g));
    irqv_src_latch i_latch (
      .clk      (clk),
      .rst      (rst),
      .src      (src_req[g]),
      .is_level (cfg_level[g]),
      .clr      (clr[g]),
      .pend     (pend[g])
    );
  end

  irqv_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) i_arb (
    .pend  (pend),
    .prio  (cfg_prio),
    .mask  (mask_q),
    .found (found),
    .idx   (found_idx),
    .lvl   (found_lvl)
  );

  irqv_sequencer #(.IDX_W(IDX_W), .RES_CYC(RES_CYC)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .found     (found),
    .found_idx (found_idx),
    .found_lvl (found_lvl),
    .irq_o     (irq_o),
    .vec_o     (vec),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  // mask register: the acknowledge takes precedence over a bus write
  always_ff @(posedge clk) begin
    if (rst)                                     mask_q <= LVL_OFF;
    else if (ack)                                mask_q <= win_lvl;
    else if (bus_wr && bus_addr == REG_MASK)     mask_q <= bus_wdata[LVL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= (bus_addr == REG_MASK) ? {{(16-LVL_W){1'b0}}, mask_q} : vec;
  end

  // R7: the acknowledge drops the request in the next cycle
  a_r7_ack_drops: assert property (@(posedge clk) disable iff (rst)
    ack |=> !irq_o);

  // R8: the acknowledge loads the winner's level into the mask
  a_r8_mask_load: assert property (@(posedge clk) disable iff (rst)
    ack |=> (mask_q == $past(win_lvl)));

  // R4: an accepted source was more urgent than the mask it was judged against
  a_r4_eligible: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (win_lvl < $past(mask_q)));

  // R10: a vector read with nothing outstanding leaves the mask alone
  a_r10_quiet_read: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && !irq_o && !bus_wr) |=> $stable(mask_q));
endmodule

// File: tb/test_irq_vector_ack.sv
`timescale 1ns/1ps
module test_irq_vector_ack;
  localparam int NSRC = 8;
  localparam int RC   = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_req = '0;
  logic [NSRC*3-1:0] cfg_prio;
  logic [NSRC-1:0] cfg_level;
  logic            bus_addr = 1'b0;
  logic            bus_rd = 1'b0;
  logic            bus_wr = 1'b0;
  logic [15:0]     bus_wdata = '0;
  logic [15:0]     bus_rdata;
  logic            irq_o;

  always #2 clk = ~clk;

  irq_vector_ack #(.NSRC(NSRC), .RES_CYC(RC)) i_irq_vector_ack (
    .clk(clk), .rst(rst), .src_req(src_req), .cfg_prio(cfg_prio),
    .cfg_level(cfg_level), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit m_pend[NSRC];
  bit m_prev[NSRC];
  int m_mask, m_cnt, m_vec, m_win, m_wlvl, m_rdata;
  bit m_irq, m_vec_ok, m_rd_ok;

  function automatic int lvl_of(int i);
    return int'(cfg_prio[i*3 +: 3]);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NSRC; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
    m_mask = 7; m_cnt = 0; m_irq = 0; m_win = 0; m_wlvl = 7;
    m_vec_ok = 0; m_rd_ok = 0; m_rdata = 0;
  endtask

  task automatic model_clock();
    bit n_pend[NSRC];
    bit ack;
    int best, bidx;
    ack = bus_rd && bus_addr == 1'b0 && m_irq;
    m_rd_ok = 0;
    if (bus_rd) begin
      if (bus_addr) begin m_rdata = m_mask; m_rd_ok = 1; end
      else if (m_vec_ok) begin m_rdata = m_vec; m_rd_ok = 1; end
    end
    for (int i = 0; i < NSRC; i++) begin
      if (cfg_level[i]) n_pend[i] = src_req[i];
      else n_pend[i] = (m_pend[i] && !(ack && m_win == i)) || (src_req[i] && !m_prev[i]);
    end
    if (ack) begin
      m_irq = 0; m_cnt = 0; m_mask = m_wlvl;
    end else begin
      if (bus_wr && bus_addr) m_mask_write();
      if (!m_irq) begin
        if (m_cnt == RC - 1) begin
          best = 7; bidx = -1;
          for (int i = 0; i < NSRC; i++)
            if (m_pend[i] && lvl_of(i) < m_mask_old && lvl_of(i) < best) begin
              best = lvl_of(i); bidx = i;
            end
          m_cnt = 0;
          if (bidx >= 0) begin
            m_irq = 1; m_win = bidx; m_wlvl = best;
            m_vec = 'h94 + 4 * bidx; m_vec_ok = 1;
          end
        end else m_cnt++;
      end
    end
    for (int i = 0; i < NSRC; i++) begin m_pend[i] = n_pend[i]; m_prev[i] = src_req[i]; end
  endtask

  // the winner is judged against the mask before this edge's write
  int m_mask_old;
  int m_mask_new;
  task automatic m_mask_write();
    m_mask_new = int'(bus_wdata[2:0]);
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) model_reset();
    else begin
      m_mask_old = m_mask;
      m_mask_new = m_mask;
      model_clock();
      if (!(bus_rd && bus_addr == 1'b0 && m_irq === 1'bx)) begin end
      if (m_mask == m_mask_old) m_mask = m_mask_new;
    end
    @(negedge clk);
    if (!rst) begin
      check("R6 request line timing", int'(irq_o), int'(m_irq));
      if (m_rd_ok) check("R11 read data", int'(bus_rdata), m_rdata);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic rd(bit a, output int v);
    bus_addr = a; bus_rd = 1; step(); bus_rd = 0; v = int'(bus_rdata);
  endtask

  task automatic wr(bit a, int d);
    bus_addr = a; bus_wr = 1; bus_wdata = 16'(d); step(); bus_wr = 0;
  endtask

  task automatic pulse(logic [NSRC-1:0] m);
    src_req = src_req | m; step(); src_req = src_req & ~m; step();
  endtask

  task automatic wait_irq(string tag);
    int k;
    k = 0;
    while (!irq_o && k < 40) begin step(); k++; end
    check(tag, int'(irq_o), 1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    // levels: s0=3 s1=1 s2=1 s3=5 s4=7 s5=2 s6=4 s7=6 ; s5 level-recognized
    cfg_prio  = {3'd6, 3'd4, 3'd2, 3'd7, 3'd5, 3'd1, 3'd1, 3'd3};
    cfg_level = 8'b0010_0000;
    model_reset();
    @(negedge clk);
    idle(3);
    rst = 0;
    idle(2);
    // R1: reset state
    check("R1 irq after reset", int'(irq_o), 0);
    rd(1, v); check("R1 mask after reset", v, 7);
    idle(6);
    check("R1 nothing pending", int'(irq_o), 0);

    // R2: two edges on s3 while masked merge into one request
    wr(1, 0);
    pulse(8'h08); idle(1); pulse(8'h08);
    idle(6);
    check("R4 masked source waits", int'(irq_o), 0);
    wr(1, 7);
    wait_irq("R2 edge accepted");
    rd(0, v); check("R6 vector of s3", v, 'hA0);
    check("R7 request dropped", int'(irq_o), 0);
    rd(1, v); check("R8 mask loaded with level 5", v, 5);
    wr(1, 7);
    rd(1, v); check("R11 mask write readback", v, 7);
    idle(12);
    check("R2 merged edges give one request", int'(irq_o), 0);
    check("R9 edge request cleared", int'(irq_o), 0);

    // R5: equal levels, lower index wins
    wr(1, 0);
    pulse(8'h06);
    wr(1, 7);
    wait_irq("R5 tie accepted");
    rd(0, v); check("R5 tie goes to s1", v, 'h98);
    idle(10);
    check("R4 equal level to mask not eligible", int'(irq_o), 0);
    wr(1, 7);
    wait_irq("R5 s2 after mask restore");
    rd(0, v); check("R5 then s2", v, 'h9C);
    wr(1, 7);

    // R3: level source survives the acknowledge
    src_req[5] = 1'b1;
    wait_irq("R3 level accepted");
    rd(0, v); check("R3 vector of s5", v, 'hA8);
    wr(1, 7);
    wait_irq("R3 level accepted again");
    rd(0, v); check("R3 vector of s5 again", v, 'hA8);
    src_req[5] = 1'b0;
    wr(1, 7);
    idle(12);
    check("R3 released level source quiet", int'(irq_o), 0);

    // R4: level 7 never wins
    pulse(8'h10);
    idle(12);
    check("R4 disabled source ignored", int'(irq_o), 0);

    // R10: vector read with nothing outstanding
    wr(1, 4);
    rd(0, v); check("R10 quiet read returns last vector", v, 'hA8);
    rd(1, v); check("R10 mask untouched", v, 4);
    idle(8);
    check("R10 no request raised", int'(irq_o), 0);
    wr(1, 7);

    // R12: vector register ignores writes
    wr(0, 'h1234);
    rd(0, v); check("R12 vector read-only", v, 'hA8);

    // R5: levels ordered across three sources
    wr(1, 0);
    pulse(8'h49);
    wr(1, 7);
    wait_irq("R5 first of three");
    rd(0, v); check("R5 level 3 first", v, 'h94);
    wr(1, 7);
    wait_irq("R5 second of three");
    rd(0, v); check("R5 level 4 next", v, 'hAC);
    wr(1, 7);
    wait_irq("R5 third of three");
    rd(0, v); check("R5 level 5 last", v, 'hA0);
    wr(1, 7);
    idle(10);
    check("R9 all edge requests consumed", int'(irq_o), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule